// File: doc/BRIEF.md
# Uncacheable Load Entry Tracker

This block follows a single uncacheable load from the cycle it is placed in a queue slot until it is written back to a load port or discarded by a pipeline redirect. It stores the load's payload, its kind (memory-mapped I/O or non-cacheable memory), its age tag and a four-state lifecycle: Idle, Request, Response and Wait. It also stores the tag that the downstream uncache buffer assigns to the load. The surrounding queue instantiates one copy per slot. It picks among the copies' send-ready and writeback-valid outputs and feeds each copy its accept strobes.

An I/O load is held back until it reaches the head of the reorder buffer. A non-cacheable load may go out as soon as it is resident. When a redirect hits a load that has already gone to the bus, the block cannot free it at once, because every bus request must be paired with its own response. The flush is therefore recorded, and the slot is released only when the matching response arrives. A bus error (corrupt or denied) is kept and presented with the writeback.

Top module: `ucl_entry`

## Requirements
- R1: After reset, send_ready, wb_valid_io, wb_valid_nc and free_pulse are all low.
- R2: A non-cacheable entry (alloc_is_io=0) becomes resident at the edge that samples alloc_valid. It is still Idle in the cycle after that edge, and send_ready is high from the next edge on.
- R3: An I/O entry raises send_ready only at the edge after head_valid=1 and head_age equal to its own age have been sampled. Before that it stays low.
- R4: send_ready together with req_accept moves the entry to Response, and send_ready then drops. An ID response is taken only when idresp_mid equals the ENTRY_ID parameter. A bus response completes the entry only after that, and only when resp_sid equals the recorded tag. Any other response is ignored.
- R5: In Wait, an I/O entry drives wb_valid_io and a non-cacheable entry drives wb_valid_nc, never both. The signal holds until the accept of that same kind arrives. An accept of the other kind has no effect. The accepting edge empties the entry.
- R6: Age tags have a wrap flag in the MSB and an index below it. Tag A is younger than tag B when the flags are equal and A's index is larger, or when the flags differ and A's index is smaller. A redirect affects only entries younger than redir_age.
- R7: A redirect that hits an entry in Idle, Request (without a same-cycle accept) or Wait empties it at that edge.
- R8: A redirect that hits an entry in Response keeps it resident, with no send_ready and no writeback. The entry is emptied at the edge that samples its matching bus response, and it produces no writeback.
- R9: wb_exc equals resp_corrupt OR resp_denied as sampled with the completing response, and is shown while the writeback is valid.
- R10: If alloc_valid arrives together with a redirect and alloc_age is younger than redir_age, the load is never made resident.
- R11: alloc_valid is ignored while the entry is resident.
- R12: wb_payload equals the alloc_payload given at allocation.
- R13: free_pulse is high for exactly one cycle, in the cycle after any edge that empties the entry or discards an allocation. It is high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Place a new load in this slot |
| alloc_is_io | input | 1 | 1 = I/O load, 0 = non-cacheable load |
| alloc_age | input | AGE_W | Age tag of the new load |
| alloc_payload | input | PAYLOAD_W | Load payload to keep |
| head_valid | input | 1 | Reorder-buffer head tag is valid |
| head_age | input | AGE_W | Age tag at the reorder-buffer head |
| send_ready | output | 1 | Entry is in Request and asks to be sent |
| req_accept | input | 1 | Selector's holding register took this entry |
| idresp_valid | input | 1 | ID response from the uncache buffer |
| idresp_mid | input | MID_W | Queue slot the ID response belongs to |
| idresp_sid | input | SID_W | Buffer tag assigned to the load |
| resp_valid | input | 1 | Bus response valid |
| resp_sid | input | SID_W | Buffer tag of the bus response |
| resp_corrupt | input | 1 | Bus data corrupt |
| resp_denied | input | 1 | Bus access denied |
| wb_valid_io | output | 1 | I/O writeback pending |
| wb_valid_nc | output | 1 | Non-cacheable writeback pending |
| wb_payload | output | PAYLOAD_W | Payload for the writeback |
| wb_exc | output | 1 | Bus error travels with the writeback |
| wb_accept_io | input | 1 | Load port took the I/O writeback |
| wb_accept_nc | input | 1 | Load port took the non-cacheable writeback |
| redir_valid | input | 1 | Pipeline redirect |
| redir_age | input | AGE_W | Age tag of the redirecting instruction |
| free_pulse | output | 1 | Slot returned to the free list |

## Verification
The assertions check on every cycle the properties that concern a single step. An accepted request always leaves Request. A deferred flush stays parked in Response until its own response arrives, and then releases the slot. A writeback accept frees the slot on the next cycle. The exception bit on a new writeback matches the error inputs of the completing response. Only the bench scenarios can show the multi-cycle behaviour. These include the I/O load waiting for the reorder-buffer head, responses with a foreign tag or slot number being ignored, the wrap-flag age ordering, and an allocation discarded by a same-cycle redirect never reappearing.

// File: rtl/ucl_pkg.sv
// Shared types for the uncacheable-load entry tracker.
// Assumes: four lifecycle states fit in two bits.
package ucl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2,
        ST_WAIT = 2'd3
    } ent_state_t;

endpackage

// File: rtl/ucl_age_cmp.sv
// Age comparator: reports whether tag a is younger than tag b.
// Assumes: MSB of each tag is a wrap flag, the rest a circular index,
// and the two tags are never more than one lap apart.
module ucl_age_cmp #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_younger
);
    localparam int unsigned IDX_W = W - 1;

    logic             same_lap;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;

    // Split the tags and order them, flipping the sense across a wrap.
    always_comb begin
        same_lap  = (a[W-1] == b[W-1]);
        a_idx     = a[IDX_W-1:0];
        b_idx     = b[IDX_W-1:0];
        a_younger = same_lap ? (a_idx > b_idx) : (a_idx < b_idx);
    end
endmodule

// File: rtl/ucl_entry_store.sv
// Data store of one entry: kind, age, payload, buffer tag and error bit.
// Assumes: the lifecycle controller gives the load strobes; reset clears all.
module ucl_entry_store #(
    parameter int unsigned AGE_W     = 6,
    parameter int unsigned PAYLOAD_W = 16,
    parameter int unsigned SID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_alloc,
    input  logic                 alloc_is_io,
    input  logic [AGE_W-1:0]     alloc_age,
    input  logic [PAYLOAD_W-1:0] alloc_payload,
    input  logic                 ld_id,
    input  logic [SID_W-1:0]     id_sid,
    input  logic                 ld_exc,
    input  logic                 exc_in,
    output logic                 is_io_q,
    output logic [AGE_W-1:0]     age_q,
    output logic [PAYLOAD_W-1:0] payload_q,
    output logic                 acc_q,
    output logic [SID_W-1:0]     sid_q,
    output logic                 exc_q
);
    // Request fields: captured once at allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_io_q   <= 1'b0;
            age_q     <= '0;
            payload_q <= '0;
        end else if (ld_alloc) begin
            is_io_q   <= alloc_is_io;
            age_q     <= alloc_age;
            payload_q <= alloc_payload;
        end
    end

    // Buffer acceptance flag and tag: cleared at allocation, set by the ID response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            sid_q <= '0;
        end else if (ld_alloc) begin
            acc_q <= 1'b0;
            sid_q <= '0;
        end else if (ld_id) begin
            acc_q <= 1'b1;
            sid_q <= id_sid;
        end
    end

    // Error bit: cleared at allocation, loaded from the completing response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
        end else if (ld_alloc) begin
            exc_q <= 1'b0;
        end else if (ld_exc) begin
            exc_q <= exc_in;
        end
    end
endmodule

// File: rtl/ucl_entry_fsm.sv
// Lifecycle controller of one entry: valid bit, four-state register,
// deferred-flush flag and free-list release pulse.
// Assumes: all event inputs are already qualified by the top (tag matches,
// age comparisons); a bus response is only reported while in Response.
module ucl_entry_fsm
    import ucl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc_valid,
    input  logic       alloc_kill,
    input  logic       eligible,
    input  logic       req_accept,
    input  logic       resp_hit,
    input  logic       wb_accept,
    input  logic       redir_hit,
    output logic       valid_q,
    output ent_state_t state_q,
    output logic       flush_pend_q,
    output logic       free_pulse,
    output logic       ld_alloc,
    output logic       ld_exc
);
    logic       valid_d;
    ent_state_t state_d;
    logic       flush_pend_d;
    logic       free_now;

    // Next-state decision for allocation, normal progress and flushes.
    always_comb begin
        valid_d      = valid_q;
        state_d      = state_q;
        flush_pend_d = flush_pend_q;
        free_now     = 1'b0;
        ld_alloc     = 1'b0;
        ld_exc       = 1'b0;
        if (!valid_q) begin
            if (alloc_valid) begin
                if (alloc_kill) begin
                    free_now = 1'b1;
                end else begin
                    valid_d  = 1'b1;
                    state_d  = ST_IDLE;
                    ld_alloc = 1'b1;
                end
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (redir_hit)     free_now = 1'b1;
                    else if (eligible) state_d  = ST_REQ;
                end
                ST_REQ: begin
                    if (req_accept) begin
                        state_d = ST_RESP;
                        if (redir_hit) flush_pend_d = 1'b1;
                    end else if (redir_hit) begin
                        free_now = 1'b1;
                    end
                end
                ST_RESP: begin
                    if (resp_hit) begin
                        if (flush_pend_q || redir_hit) begin
                            free_now = 1'b1;
                        end else begin
                            state_d = ST_WAIT;
                            ld_exc  = 1'b1;
                        end
                    end else if (redir_hit) begin
                        flush_pend_d = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (redir_hit || wb_accept) free_now = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
            if (free_now) begin
                valid_d      = 1'b0;
                state_d      = ST_IDLE;
                flush_pend_d = 1'b0;
            end
        end
    end

    // Lifecycle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q      <= 1'b0;
            state_q      <= ST_IDLE;
            flush_pend_q <= 1'b0;
        end else begin
            valid_q      <= valid_d;
            state_q      <= state_d;
            flush_pend_q <= flush_pend_d;
        end
    end

    // Release pulse to the free list, one cycle after the slot empties.
    always_ff @(posedge clk) begin
        if (!rst_n) free_pulse <= 1'b0;
        else        free_pulse <= free_now;
    end
endmodule

// File: rtl/ucl_entry.sv
// One queue slot for an uncacheable load: qualifies eligibility, tag matches,
// redirect age hits and writeback accepts, then drives the lifecycle
// controller and the data store.
// Assumes: the enclosing queue performs all arbitration between slots.
module ucl_entry
    import ucl_pkg::*;
#(
    parameter int unsigned AGE_W     = 6,
    parameter int unsigned PAYLOAD_W = 16,
    parameter int unsigned SID_W     = 2,
    parameter int unsigned MID_W     = 2,
    parameter int unsigned ENTRY_ID  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic                 alloc_is_io,
    input  logic [AGE_W-1:0]     alloc_age,
    input  logic [PAYLOAD_W-1:0] alloc_payload,
    input  logic                 head_valid,
    input  logic [AGE_W-1:0]     head_age,
    output logic                 send_ready,
    input  logic                 req_accept,
    input  logic                 idresp_valid,
    input  logic [MID_W-1:0]     idresp_mid,
    input  logic [SID_W-1:0]     idresp_sid,
    input  logic                 resp_valid,
    input  logic [SID_W-1:0]     resp_sid,
    input  logic                 resp_corrupt,
    input  logic                 resp_denied,
    output logic                 wb_valid_io,
    output logic                 wb_valid_nc,
    output logic [PAYLOAD_W-1:0] wb_payload,
    output logic                 wb_exc,
    input  logic                 wb_accept_io,
    input  logic                 wb_accept_nc,
    input  logic                 redir_valid,
    input  logic [AGE_W-1:0]     redir_age,
    output logic                 free_pulse
);
    localparam logic [MID_W-1:0] SELF_ID = MID_W'(ENTRY_ID);

    logic                 valid_q;
    ent_state_t           state_q;
    logic                 flush_pend_q;
    logic                 ld_alloc;
    logic                 ld_exc;
    logic                 is_io_q;
    logic [AGE_W-1:0]     age_q;
    logic [PAYLOAD_W-1:0] payload_q;
    logic                 acc_q;
    logic [SID_W-1:0]     sid_q;
    logic                 exc_q;
    logic                 alloc_after_redir;
    logic                 entry_after_redir;
    logic                 alloc_kill;
    logic                 redir_hit;
    logic                 eligible;
    logic                 id_hit;
    logic                 resp_hit;
    logic                 wb_accept;
    logic                 in_wait;

    // Age of an incoming load against the redirect.
    ucl_age_cmp #(.W(AGE_W)) u_alloc_cmp (
        .a         (alloc_age),
        .b         (redir_age),
        .a_younger (alloc_after_redir)
    );

    // Age of the resident load against the redirect.
    ucl_age_cmp #(.W(AGE_W)) u_entry_cmp (
        .a         (age_q),
        .b         (redir_age),
        .a_younger (entry_after_redir)
    );

    // Event qualification for the lifecycle controller and store.
    always_comb begin
        alloc_kill = redir_valid && alloc_after_redir;
        redir_hit  = redir_valid && entry_after_redir;
        eligible   = is_io_q ? (head_valid && (head_age == age_q)) : 1'b1;
        id_hit     = valid_q && (state_q == ST_RESP) && !acc_q
                     && idresp_valid && (idresp_mid == SELF_ID);
        resp_hit   = valid_q && (state_q == ST_RESP) && acc_q
                     && resp_valid && (resp_sid == sid_q);
        wb_accept  = is_io_q ? wb_accept_io : wb_accept_nc;
    end

    ucl_entry_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_kill   (alloc_kill),
        .eligible     (eligible),
        .req_accept   (req_accept),
        .resp_hit     (resp_hit),
        .wb_accept    (wb_accept),
        .redir_hit    (redir_hit),
        .valid_q      (valid_q),
        .state_q      (state_q),
        .flush_pend_q (flush_pend_q),
        .free_pulse   (free_pulse),
        .ld_alloc     (ld_alloc),
        .ld_exc       (ld_exc)
    );

    ucl_entry_store #(
        .AGE_W     (AGE_W),
        .PAYLOAD_W (PAYLOAD_W),
        .SID_W     (SID_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_alloc      (ld_alloc),
        .alloc_is_io   (alloc_is_io),
        .alloc_age     (alloc_age),
        .alloc_payload (alloc_payload),
        .ld_id         (id_hit),
        .id_sid        (idresp_sid),
        .ld_exc        (ld_exc),
        .exc_in        (resp_corrupt || resp_denied),
        .is_io_q       (is_io_q),
        .age_q         (age_q),
        .payload_q     (payload_q),
        .acc_q         (acc_q),
        .sid_q         (sid_q),
        .exc_q         (exc_q)
    );

    // Output decode from the lifecycle state.
    always_comb begin
        in_wait     = valid_q && (state_q == ST_WAIT);
        send_ready  = valid_q && (state_q == ST_REQ);
        wb_valid_io = in_wait && is_io_q;
        wb_valid_nc = in_wait && !is_io_q;
        wb_payload  = payload_q;
        wb_exc      = in_wait && exc_q;
    end
endmodule

// File: rtl/ucl_entry_chk.sv
// Protocol checker for ucl_entry, attached with bind.
// Assumes: connected to the top's ports and lifecycle signals.
module ucl_entry_chk
    import ucl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       send_ready,
    input logic       req_accept,
    input logic       wb_valid_io,
    input logic       wb_valid_nc,
    input logic       wb_exc,
    input logic       wb_accept_io,
    input logic       wb_accept_nc,
    input logic       resp_corrupt,
    input logic       resp_denied,
    input logic       free_pulse,
    input logic       valid_q,
    input ent_state_t state_q,
    input logic       flush_pend_q,
    input logic       resp_hit
);
    AST_ACCEPT_LEAVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (send_ready && req_accept) |=> (valid_q && !send_ready)); // R4

    AST_WB_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid_io && wb_valid_nc)); // R5

    AST_WB_ACCEPT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        ((wb_valid_io && wb_accept_io) || (wb_valid_nc && wb_accept_nc))
        |=> (free_pulse && !wb_valid_io && !wb_valid_nc)); // R5

    AST_DEFER_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend_q |-> (valid_q && state_q == ST_RESP && !send_ready)); // R8

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend_q && !resp_hit) |=> (valid_q && !free_pulse)); // R8

    AST_DEFER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend_q && resp_hit) |=> (free_pulse && !valid_q && !wb_valid_io && !wb_valid_nc)); // R8

    AST_EXC_FROM_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid_io || wb_valid_nc) |-> (wb_exc == $past(resp_corrupt || resp_denied))); // R9

    AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        free_pulse |-> !valid_q); // R13
endmodule

bind ucl_entry ucl_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .send_ready   (send_ready),
    .req_accept   (req_accept),
    .wb_valid_io  (wb_valid_io),
    .wb_valid_nc  (wb_valid_nc),
    .wb_exc       (wb_exc),
    .wb_accept_io (wb_accept_io),
    .wb_accept_nc (wb_accept_nc),
    .resp_corrupt (resp_corrupt),
    .resp_denied  (resp_denied),
    .free_pulse   (free_pulse),
    .valid_q      (valid_q),
    .state_q      (state_q),
    .flush_pend_q (flush_pend_q),
    .resp_hit     (resp_hit)
);

// File: tb/ucl_entry_test.sv
// Directed bench for ucl_entry: one task per scenario, each checking itself.
module ucl_entry_test;
    localparam int CLK_PERIOD = 10;
    localparam int AGE_W = 6;
    localparam int PW    = 16;
    localparam int SW    = 2;
    localparam int MW    = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alloc_valid, alloc_is_io;
    logic [AGE_W-1:0] alloc_age;
    logic [PW-1:0] alloc_payload;
    logic          head_valid;
    logic [AGE_W-1:0] head_age;
    logic          send_ready, req_accept;
    logic          idresp_valid;
    logic [MW-1:0] idresp_mid;
    logic [SW-1:0] idresp_sid;
    logic          resp_valid;
    logic [SW-1:0] resp_sid;
    logic          resp_corrupt, resp_denied;
    logic          wb_valid_io, wb_valid_nc;
    logic [PW-1:0] wb_payload;
    logic          wb_exc, wb_accept_io, wb_accept_nc;
    logic          redir_valid;
    logic [AGE_W-1:0] redir_age;
    logic          free_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucl_entry #(.AGE_W(AGE_W), .PAYLOAD_W(PW), .SID_W(SW), .MID_W(MW), .ENTRY_ID(1)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_io(alloc_is_io),
        .alloc_age(alloc_age), .alloc_payload(alloc_payload),
        .head_valid(head_valid), .head_age(head_age),
        .send_ready(send_ready), .req_accept(req_accept),
        .idresp_valid(idresp_valid), .idresp_mid(idresp_mid), .idresp_sid(idresp_sid),
        .resp_valid(resp_valid), .resp_sid(resp_sid),
        .resp_corrupt(resp_corrupt), .resp_denied(resp_denied),
        .wb_valid_io(wb_valid_io), .wb_valid_nc(wb_valid_nc),
        .wb_payload(wb_payload), .wb_exc(wb_exc),
        .wb_accept_io(wb_accept_io), .wb_accept_nc(wb_accept_nc),
        .redir_valid(redir_valid), .redir_age(redir_age),
        .free_pulse(free_pulse)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        alloc_valid = 0; alloc_is_io = 0; alloc_age = '0; alloc_payload = '0;
        head_valid = 0; head_age = '0; req_accept = 0;
        idresp_valid = 0; idresp_mid = '0; idresp_sid = '0;
        resp_valid = 0; resp_sid = '0; resp_corrupt = 0; resp_denied = 0;
        wb_accept_io = 0; wb_accept_nc = 0; redir_valid = 0; redir_age = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Allocate a load, let it reach Request, get it accepted and tagged.
    task automatic bring_up(logic io, logic [AGE_W-1:0] age, logic [PW-1:0] pl, logic [SW-1:0] sid);
        alloc_valid = 1; alloc_is_io = io; alloc_age = age; alloc_payload = pl;
        step(); alloc_valid = 0;
        if (io) begin head_valid = 1; head_age = age; end
        step(); head_valid = 0;
        req_accept = 1; step(); req_accept = 0;
        idresp_valid = 1; idresp_mid = 2'd1; idresp_sid = sid; step(); idresp_valid = 0;
    endtask

    task automatic t_reset();
        check("R1", "send_ready", send_ready, 0);
        check("R1", "wb_valid_io|nc", {wb_valid_io, wb_valid_nc}, 0);
        check("R13", "free_pulse at reset", free_pulse, 0);
    endtask

    task automatic t_nc_life();
        alloc_valid = 1; alloc_is_io = 0; alloc_age = 6'd5; alloc_payload = 16'hA5A5;
        step(); alloc_valid = 0;
        check("R2", "send_ready one cycle after alloc", send_ready, 0);
        step();
        check("R2", "send_ready nc eligible", send_ready, 1);
        req_accept = 1; step(); req_accept = 0;
        check("R4", "send_ready after accept", send_ready, 0);
        idresp_valid = 1; idresp_mid = 2'd1; idresp_sid = 2'd2; step(); idresp_valid = 0;
        resp_valid = 1; resp_sid = 2'd1; step(); resp_valid = 0;
        check("R4", "foreign sid ignored", wb_valid_nc, 0);
        resp_valid = 1; resp_sid = 2'd2; step(); resp_valid = 0;
        check("R5", "wb_valid_nc", wb_valid_nc, 1);
        check("R5", "wb_valid_io", wb_valid_io, 0);
        check("R12", "payload", wb_payload, 16'hA5A5);
        check("R9", "no exception", wb_exc, 0);
        wb_accept_io = 1; step(); wb_accept_io = 0;
        check("R5", "other-kind accept ignored", wb_valid_nc, 1);
        check("R13", "no free on other accept", free_pulse, 0);
        alloc_valid = 1; alloc_age = 6'd9; alloc_payload = 16'h1234; step(); alloc_valid = 0;
        check("R11", "alloc while resident ignored", wb_payload, 16'hA5A5);
        wb_accept_nc = 1; step(); wb_accept_nc = 0;
        check("R5", "wb dropped after accept", wb_valid_nc, 0);
        check("R13", "free pulse after writeback", free_pulse, 1);
        step();
        check("R13", "free pulse one cycle", free_pulse, 0);
    endtask

    task automatic t_io_life();
        alloc_valid = 1; alloc_is_io = 1; alloc_age = 6'd7; alloc_payload = 16'h0707;
        head_valid = 1; head_age = 6'd3;
        step(); alloc_valid = 0;
        step(); step();
        check("R3", "io held off head", send_ready, 0);
        head_age = 6'd7; step(); head_valid = 0;
        check("R3", "io ready at head", send_ready, 1);
        req_accept = 1; step(); req_accept = 0;
        idresp_valid = 1; idresp_mid = 2'd2; idresp_sid = 2'd3; step(); idresp_valid = 0;
        resp_valid = 1; resp_sid = 2'd3; step(); resp_valid = 0;
        check("R4", "foreign mid ignored", wb_valid_io, 0);
        idresp_valid = 1; idresp_mid = 2'd1; idresp_sid = 2'd3; step(); idresp_valid = 0;
        resp_valid = 1; resp_sid = 2'd3; resp_denied = 1; step(); resp_valid = 0; resp_denied = 0;
        check("R5", "wb_valid_io", wb_valid_io, 1);
        check("R5", "wb_valid_nc quiet", wb_valid_nc, 0);
        check("R9", "denied flagged", wb_exc, 1);
        wb_accept_io = 1; step(); wb_accept_io = 0;
        check("R13", "free after io writeback", free_pulse, 1);
        step();
    endtask

    task automatic t_corrupt();
        bring_up(1'b0, 6'd11, 16'hBEEF, 2'd0);
        resp_valid = 1; resp_sid = 2'd0; resp_corrupt = 1; step(); resp_valid = 0; resp_corrupt = 0;
        check("R9", "corrupt flagged", wb_exc, 1);
        wb_accept_nc = 1; step(); wb_accept_nc = 0;
        step();
    endtask

    task automatic t_flush_early();
        alloc_valid = 1; alloc_is_io = 0; alloc_age = 6'd10; alloc_payload = 16'h0A0A;
        step(); alloc_valid = 0;
        redir_valid = 1; redir_age = 6'd12; step(); redir_valid = 0;
        check("R6", "older entry kept", free_pulse, 0);
        check("R6", "older entry proceeds", send_ready, 1);
        redir_valid = 1; redir_age = 6'd8; step(); redir_valid = 0;
        check("R7", "flushed in request", free_pulse, 1);
        check("R7", "no send after flush", send_ready, 0);
        step();
        check("R7", "stays empty", send_ready, 0);
    endtask

    task automatic t_wait_flush();
        bring_up(1'b0, 6'd3, 16'h3333, 2'd0);
        resp_valid = 1; resp_sid = 2'd0; step(); resp_valid = 0;
        check("R5", "reached wait", wb_valid_nc, 1);
        redir_valid = 1; redir_age = 6'd1; step(); redir_valid = 0;
        check("R7", "flush in wait frees", free_pulse, 1);
        check("R7", "flush in wait drops wb", wb_valid_nc, 0);
        step();
    endtask

    task automatic t_defer();
        bring_up(1'b0, 6'd4, 16'h4444, 2'd1);
        redir_valid = 1; redir_age = 6'd2; step(); redir_valid = 0;
        check("R8", "not freed while on bus", free_pulse, 0);
        step(); step();
        check("R8", "still held", free_pulse, 0);
        check("R8", "no wb while held", wb_valid_nc, 0);
        check("R8", "no send while held", send_ready, 0);
        resp_valid = 1; resp_sid = 2'd1; step(); resp_valid = 0;
        check("R8", "freed on response", free_pulse, 1);
        check("R8", "no wb after deferred flush", wb_valid_nc, 0);
        step();
        check("R13", "single pulse", free_pulse, 0);
    endtask

    task automatic t_alloc_redir();
        alloc_valid = 1; alloc_is_io = 0; alloc_age = 6'd20; alloc_payload = 16'h2020;
        redir_valid = 1; redir_age = 6'd15;
        step(); alloc_valid = 0; redir_valid = 0;
        check("R10", "discarded alloc returns slot", free_pulse, 1);
        step();
        check("R10", "discarded alloc never ready", send_ready, 0);
        check("R13", "pulse ends", free_pulse, 0);
        alloc_valid = 1; alloc_age = 6'd14; alloc_payload = 16'h1414;
        redir_valid = 1; redir_age = 6'd15;
        step(); alloc_valid = 0; redir_valid = 0;
        check("R10", "older alloc kept", free_pulse, 0);
        step();
        check("R10", "older alloc proceeds", send_ready, 1);
        redir_valid = 1; redir_age = 6'd0; step(); redir_valid = 0;
        step();
    endtask

    task automatic t_wrap();
        alloc_valid = 1; alloc_is_io = 0; alloc_age = 6'h22; alloc_payload = 16'h2222;
        step(); alloc_valid = 0;
        redir_valid = 1; redir_age = 6'h1E; step(); redir_valid = 0;
        check("R6", "younger across wrap flushed", free_pulse, 1);
        step();
        alloc_valid = 1; alloc_age = 6'h1E; redir_valid = 1; redir_age = 6'h22;
        step(); alloc_valid = 0; redir_valid = 0;
        check("R6", "older across wrap kept", free_pulse, 0);
        step();
        check("R6", "older across wrap proceeds", send_ready, 1);
        redir_valid = 1; redir_age = 6'h10; step(); redir_valid = 0;
        check("R6", "same lap younger flushed", free_pulse, 1);
        step();
    endtask

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_nc_life();
        t_io_life();
        t_corrupt();
        t_flush_early();
        t_wait_flush();
        t_defer();
        t_alloc_redir();
        t_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule